// File: doc/BRIEF.md
# Tributary Transmit Justification Controller

This block takes a low-rate tributary bit stream, whose clock may be jittery or bursty, into the domain of the fast system clock. It does not use the tributary clock as a clock. A chain of system-clock flops samples that clock. A detected rising edge becomes a write enable that lasts one cycle, and the tributary data bit is captured into a small bit FIFO on that cycle.

A higher-order framer empties the FIFO. It raises a payload enable for every ordinary payload slot and a stuff-opportunity strobe for every justification slot. At a stuff opportunity the block sends a real data bit when the FIFO holds more than half its depth, and otherwise leaves the slot unused. The stuffing ratio therefore follows the fill level. The fill stays near half, and the average drain rate matches the tributary rate anywhere between "never stuffed with data" and "always stuffed with data".

The outputs are the outgoing bit, a flag that says the current slot carried a stuffed data bit, the FIFO level, and one-cycle overflow and underflow flags.

Top module: `trib_justify_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, level, out_bit, stuff_used, overflow and underflow are all 0.
- R2: Each low-to-high transition of trib_clk writes exactly one bit, however long trib_clk stays high. The bit is trib_data as sampled on the write cycle. With two synchronizer stages, level rises at the third system-clock edge after trib_clk rises.
- R3: A write that arrives while level equals the depth (16) and no read happens in the same cycle is dropped. overflow is 1 for that one cycle, and level stays at 16.
- R4: A payload enable while level is 0 gives underflow = 1 and out_bit = 0 on the next cycle, and the level does not drop.
- R5: A stuff opportunity while level is greater than half the depth (more than 8) gives stuff_used = 1 on the next cycle. out_bit then carries the oldest stored bit, and level drops by one.
- R6: A stuff opportunity while level is 8 or less gives stuff_used = 0 and out_bit = 0 on the next cycle, and the level does not drop.
- R7: A payload enable gives, on the next cycle, the oldest stored bit on out_bit. Bits leave in the order they were written.
- R8: When pay_en and stuff_opp are high in the same cycle, the cycle is treated as one payload read. stuff_used stays 0 and level drops by at most one.
- R9: When the tributary rate lies between the drain rate without stuffing and the drain rate with full stuffing, the fill-driven stuffing does three things. It keeps level within 1..15, it raises neither overflow nor underflow, and it delivers the bit stream unchanged. This holds for steady, fast, slow and bursty tributary clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed system clock |
| rst | input | 1 | Synchronous active-high reset |
| trib_clk | input | 1 | Tributary clock, sampled as data |
| trib_data | input | 1 | Tributary data bit, stable around the trib_clk rising edge |
| pay_en | input | 1 | Framer payload slot: read one bit |
| stuff_opp | input | 1 | Framer justification slot strobe |
| out_bit | output | 1 | Outgoing bit for the slot requested in the previous cycle |
| stuff_used | output | 1 | Previous-cycle justification slot carried data |
| level | output | $clog2(DEPTH+1) (5) | FIFO fill level |
| overflow | output | 1 | One-cycle pulse: a write was dropped |
| underflow | output | 1 | One-cycle pulse: a payload read found the FIFO empty |

## Verification
A wrong internal state shows up at the ports quickly. A bad read pointer or a bad storage cell puts the wrong value on out_bit one cycle after the payload enable or stuff opportunity that reads it. A miscounted fill appears on the level port at once. It also flips the stuff decision at the next justification slot, which is seen through stuff_used. A missed or doubled tributary edge leaves level off by one from the third system cycle after the tributary rise, and the delivered stream then goes out of step with the sent stream.

// File: rtl/tjc_pkg.sv
package tjc_pkg;

    localparam int unsigned TJC_DEPTH_DEF = 16;
    localparam int unsigned TJC_SYNC_DEF  = 2;

    // write request produced by the tributary edge sampler
    typedef struct packed {
        logic wr;
        logic wbit;
    } tjc_wr_t;

    // read request produced by the justification arbiter
    typedef struct packed {
        logic rd;
        logic use_stuff;
    } tjc_rd_t;

    // fill strictly above half depth
    function automatic logic tjc_above_half(input int unsigned lvl,
                                            input int unsigned depth);
        return lvl > (depth / 2);
    endfunction

endpackage

// File: rtl/tjc_edge_sampler.sv
module tjc_edge_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trib_clk,
    input  logic             trib_data,
    output tjc_pkg::tjc_wr_t wq
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // synchronizer chain; trib_clk only ever reaches a D input
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= trib_clk;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    always_comb begin
        wq.wr   = sync_q[STAGES-1] & ~last_q;
        wq.wbit = trib_data;
    end

endmodule

// File: rtl/tjc_bit_fifo.sv
module tjc_bit_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  tjc_pkg::tjc_wr_t wq,
    input  logic             rd,
    output logic             head,
    output logic [LW-1:0]    level,
    output logic             drop,
    output logic             starve
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wp, rp;
    logic             full, empty, do_rd, do_wr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full   = (level == LW'(DEPTH));
        empty  = (level == '0);
        do_rd  = rd & ~empty;
        do_wr  = wq.wr & (~full | do_rd);
        drop   = wq.wr & full & ~do_rd;
        starve = rd & empty;
        head   = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem   <= '0;
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) begin
                mem[wp] <= wq.wbit;
                wp      <= ptr_inc(wp);
            end
            if (do_rd) rp <= ptr_inc(rp);
            case ({do_wr, do_rd})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/tjc_stuff_arbiter.sv
module tjc_stuff_arbiter #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic             pay_en,
    input  logic             stuff_opp,
    input  logic [LW-1:0]    level,
    output tjc_pkg::tjc_rd_t rq
);
    // payload slot wins over a coincident justification slot
    always_comb begin
        rq.use_stuff = stuff_opp & ~pay_en &
                       tjc_pkg::tjc_above_half(32'(level), DEPTH);
        rq.rd        = pay_en | rq.use_stuff;
    end

endmodule

// File: rtl/trib_justify_ctrl.sv
module trib_justify_ctrl #(
    parameter  int unsigned DEPTH       = tjc_pkg::TJC_DEPTH_DEF,
    parameter  int unsigned SYNC_STAGES = tjc_pkg::TJC_SYNC_DEF,
    localparam int unsigned LW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trib_clk,
    input  logic          trib_data,
    input  logic          pay_en,
    input  logic          stuff_opp,
    output logic          out_bit,
    output logic          stuff_used,
    output logic [LW-1:0] level,
    output logic          overflow,
    output logic          underflow
);
    tjc_pkg::tjc_wr_t wq;
    tjc_pkg::tjc_rd_t rq;
    logic             head, drop, starve;

    tjc_edge_sampler #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .trib_clk (trib_clk),
        .trib_data(trib_data),
        .wq       (wq)
    );

    tjc_stuff_arbiter #(.DEPTH(DEPTH), .LW(LW)) u_arb (
        .pay_en   (pay_en),
        .stuff_opp(stuff_opp),
        .level    (level),
        .rq       (rq)
    );

    tjc_bit_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wq    (wq),
        .rd    (rq.rd),
        .head  (head),
        .level (level),
        .drop  (drop),
        .starve(starve)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_bit    <= 1'b0;
            stuff_used <= 1'b0;
            overflow   <= 1'b0;
            underflow  <= 1'b0;
        end else begin
            out_bit    <= (rq.rd && !starve) ? head : 1'b0;
            stuff_used <= rq.use_stuff;
            overflow   <= drop;
            underflow  <= starve;
        end
    end

endmodule

// File: rtl/tjc_checker.sv
module tjc_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          pay_en,
    input logic          stuff_opp,
    input logic          out_bit,
    input logic          stuff_used,
    input logic [LW-1:0] level,
    input logic          overflow,
    input logic          underflow
);
    localparam int unsigned HALF = DEPTH / 2;

    assert_one_write_R2: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, level} <= {1'b0, $past(level)} + (LW+1)'(1)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (level == LW'(DEPTH)));

    assert_flags_apart_R3: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

    assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        underflow |-> ($past(level) == '0 && !out_bit));

    assert_stuff_used_R5: assert property (@(posedge clk) disable iff (rst)
        stuff_used |-> (32'($past(level)) > HALF));

    assert_stuff_skip_R6: assert property (@(posedge clk) disable iff (rst)
        (stuff_opp && !pay_en && 32'(level) <= HALF) |=> (!stuff_used && !out_bit));

    assert_collision_R8: assert property (@(posedge clk) disable iff (rst)
        pay_en |=> !stuff_used);

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (32'(level) <= DEPTH));

endmodule

bind trib_justify_ctrl tjc_checker #(.DEPTH(DEPTH), .LW(LW)) u_tjc_chk (
    .clk       (clk),
    .rst       (rst),
    .pay_en    (pay_en),
    .stuff_opp (stuff_opp),
    .out_bit   (out_bit),
    .stuff_used(stuff_used),
    .level     (level),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/tb_trib_justify_ctrl.sv
module tb_trib_justify_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trib_clk = 1'b0;
    logic       trib_data = 1'b0;
    logic       pay_en = 1'b0;
    logic       stuff_opp = 1'b0;
    logic       out_bit, stuff_used, overflow, underflow;
    logic [4:0] level;

    int total = 0;
    int bad   = 0;
    bit seen_ovf = 0;
    bit seen_unf = 0;
    bit exp_q[$];

    trib_justify_ctrl dut (
        .clk(clk), .rst(rst), .trib_clk(trib_clk), .trib_data(trib_data),
        .pay_en(pay_en), .stuff_opp(stuff_opp), .out_bit(out_bit),
        .stuff_used(stuff_used), .level(level), .overflow(overflow),
        .underflow(underflow)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog (all R): actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(string req, int act, int expv, string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (overflow)  seen_ovf = 1;
        if (underflow) seen_unf = 1;
    endtask

    task automatic apply_reset();
        rst = 1; pay_en = 0; stuff_opp = 0; trib_clk = 0; trib_data = 0;
        repeat (3) step();
        rst = 0;
        step();
        seen_ovf = 0;
        seen_unf = 0;
    endtask

    task automatic trib_pulse(bit b);
        trib_data = b;
        trib_clk  = 1;
        repeat (4) step();
        trib_clk  = 0;
        repeat (4) step();
    endtask

    task automatic xfer(bit pay, bit stf, output bit ob, output bit su, output bit uf);
        pay_en = pay; stuff_opp = stf;
        step();
        pay_en = 0; stuff_opp = 0;
        ob = out_bit; su = stuff_used; uf = underflow;
    endtask

    task automatic t_reset();
        rst = 1; trib_clk = 0;
        repeat (2) step();
        check("R1", int'(level), 0, "level in reset");
        rst = 0;
        step();
        check("R1", int'(level), 0, "level after reset");
        check("R1", int'(out_bit), 0, "out_bit after reset");
        check("R1", int'(stuff_used), 0, "stuff_used after reset");
        check("R1", int'({overflow, underflow}), 0, "flags after reset");
    endtask

    task automatic t_write_timing();
        apply_reset();
        trib_data = 1; trib_clk = 1;
        step(); check("R2", int'(level), 0, "level one edge after rise");
        step(); check("R2", int'(level), 0, "level two edges after rise");
        step(); check("R2", int'(level), 1, "level three edges after rise");
        repeat (6) step();
        check("R2", int'(level), 1, "long high writes once");
        trib_clk = 0;
        repeat (4) step();
        for (int i = 0; i < 3; i++) trib_pulse(1'(i));
        check("R2", int'(level), 4, "level after four edges");
    endtask

    task automatic t_order();
        bit pat[7] = '{1, 0, 1, 1, 0, 0, 1};
        bit ob, su, uf;
        apply_reset();
        foreach (pat[i]) trib_pulse(pat[i]);
        for (int i = 0; i < 7; i++) begin
            xfer(1, 0, ob, su, uf);
            check("R7", int'(ob), int'(pat[i]), $sformatf("payload bit %0d", i));
        end
        check("R7", int'(level), 0, "level after draining");
    endtask

    task automatic t_overflow();
        bit ob, su, uf;
        apply_reset();
        for (int i = 0; i < 16; i++) trib_pulse(1'(i % 3 == 0));
        check("R3", int'(seen_ovf), 0, "no overflow up to full");
        check("R3", int'(level), 16, "level at full");
        trib_pulse(1'b0);
        check("R3", int'(seen_ovf), 1, "overflow pulse on write to full");
        check("R3", int'(level), 16, "level held at full");
        for (int i = 0; i < 16; i++) begin
            xfer(1, 0, ob, su, uf);
            check("R3", int'(ob), int'(i % 3 == 0), $sformatf("kept bit %0d", i));
        end
        check("R3", int'(level), 0, "dropped bit not stored");
    endtask

    task automatic t_underflow();
        bit ob, su, uf;
        apply_reset();
        xfer(1, 0, ob, su, uf);
        check("R4", int'(uf), 1, "underflow on empty read");
        check("R4", int'(ob), 0, "out_bit on empty read");
        check("R4", int'(level), 0, "level stays empty");
        step();
        check("R4", int'(underflow), 0, "underflow is one cycle");
    endtask

    task automatic t_stuff();
        bit ob, su, uf;
        apply_reset();
        trib_pulse(1);
        for (int i = 1; i < 8; i++) trib_pulse(0);
        xfer(0, 1, ob, su, uf);
        check("R6", int'(su), 0, "no stuff data at level 8");
        check("R6", int'(ob), 0, "out_bit idle at level 8");
        check("R6", int'(level), 8, "level kept at 8");
        trib_pulse(0);
        xfer(0, 1, ob, su, uf);
        check("R5", int'(su), 1, "stuff data at level 9");
        check("R5", int'(ob), 1, "stuffed bit is oldest");
        check("R5", int'(level), 8, "level after stuffed read");
        xfer(0, 1, ob, su, uf);
        check("R6", int'(su), 0, "back at 8, slot unused");
    endtask

    task automatic t_collision();
        bit ob, su, uf;
        apply_reset();
        trib_pulse(1);
        for (int i = 1; i < 10; i++) trib_pulse(0);
        xfer(1, 1, ob, su, uf);
        check("R8", int'(su), 0, "coincident slot not stuffed");
        check("R8", int'(ob), 1, "coincident slot reads head");
        check("R8", int'(level), 9, "single read on coincidence");
    endtask

    // closed loop: 60-cycle frame with 5 payload slots and 1 justification slot
    task automatic run_traffic(string name, int pa, int pb, int ncyc);
        int  ph = 0, per = pa, which = 0, fc = 0, mism = 0, lmin = 99, lmax = -1, used = 0;
        bit  draining = 0, prev_pay = 0, prev_stuff = 0, prev_use = 0, e;
        apply_reset();
        exp_q.delete();
        trib_data = 1'($urandom);
        for (int c = 0; c < ncyc; c++) begin
            step();
            if (prev_pay || (prev_stuff && prev_use)) begin
                if (stuff_used !== prev_use) mism++;
                if (exp_q.size() == 0) mism++;
                else begin
                    e = exp_q.pop_front();
                    if (out_bit !== e) mism++;
                end
                if (prev_use) used++;
            end else if (prev_stuff) begin
                if (stuff_used !== 1'b0 || out_bit !== 1'b0) mism++;
            end
            if (draining) begin
                if (int'(level) < lmin) lmin = int'(level);
                if (int'(level) > lmax) lmax = int'(level);
            end
            if (ph == 0) begin
                trib_clk = 1;
                exp_q.push_back(trib_data);
            end else if (ph == per / 2) begin
                trib_clk  = 0;
                trib_data = 1'($urandom);
            end
            ph++;
            if (ph == per) begin
                ph = 0; which ^= 1; per = (which != 0) ? pb : pa;
            end
            if (!draining && level >= 8) draining = 1;
            pay_en = 0; stuff_opp = 0;
            if (draining) begin
                if (fc % 12 == 0) pay_en = 1;
                else if (fc == 54) stuff_opp = 1;
                fc = (fc + 1) % 60;
            end
            prev_pay   = pay_en;
            prev_stuff = stuff_opp;
            prev_use   = stuff_opp && (level > 8);
        end
        pay_en = 0; stuff_opp = 0; trib_clk = 0;
        check("R9", mism, 0, {name, " stream and stuff mismatches (R5 R6 R7)"});
        check("R9", int'(seen_ovf), 0, {name, " overflow"});
        check("R9", int'(seen_unf), 0, {name, " underflow"});
        check("R9", int'(lmin >= 1), 1, {name, " level lower bound"});
        check("R9", int'(lmax <= 15), 1, {name, " level upper bound"});
        $display("%s: stuffed data slots=%0d level %0d..%0d", name, used, lmin, lmax);
    endtask

    initial begin
        t_reset();
        t_write_timing();
        t_order();
        t_overflow();
        t_underflow();
        t_stuff();
        t_collision();
        run_traffic("nominal", 11, 11, 6000);
        run_traffic("fast",    10, 10, 6000);
        run_traffic("slow",    12, 12, 6000);
        run_traffic("bursty",   8, 14, 6000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule